// File: doc/BRIEF.md
# RTC shadow-register update controller

This block is the register front end that a host sees in front of a real-time clock counter core. The host writes the time fields into byte-wide buffer registers and the alarm fields into a second bank of buffers. It then sets one bit in an update-control register to start a transfer between the buffers and the live side. There are three such bits. The write-update bit pushes the buffered time into the counter core as a single load. The read-update bit freezes the core's current time into snapshot registers, which the host then reads. The alarm-update bit copies the alarm buffers into the committed alarm registers.

Each bit stays set while its transfer is in flight and clears itself when the transfer completes. The host therefore polls the control register until the bit reads zero. The in-flight time is a down-count of clock cycles. The count is either a long default or a short fast value, picked by a select bit in the same control write. A mode register holds a binary/BCD select and a 24-hour select; both go to the core, and the 24-hour select also sets how the hours byte is masked on commit. An optional eighth time byte carries a second year byte.

The register bus is 8 bits wide and has no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. Read data follows `bus_addr` combinationally. The counter core cannot stall a time load or a snapshot.

Top module: `rtcsh_ctrl`

## Requirements
- R1: After reset, the control register (address 0x10), the mode register (0x11) and every snapshot byte read 0. `time_load_valid` is low and `alarm_regs` is 0.
- R2: A bus write to 0x10 with bit 0 set starts a write-update. Bit 0 then reads 1 for exactly L cycles after that write edge. In the cycle after the L-th, bit 0 reads 0 and `time_load_valid` is high for one cycle with `time_load_data` holding the masked time buffers; byte i of the load is buffer address i.
- R3: L equals LAT_FAST when bit 4 of that control write is 1, and LAT_SLOW otherwise. Bit 4 of the control register reads back the last value written.
- R4: Bit 1 of the control register starts a read-update with the same timing. At its completion, `live_time` is captured into the snapshot. Reads of addresses 0 to NREG-1 return the snapshot bytes, and the snapshot does not change at any other time.
- R5: Alarm buffers are written and read at 0x08+i. Bit 2 of the control register starts an alarm-update. `alarm_regs` takes the buffers at completion and holds its value otherwise.
- R6: With ALARM_STICKY=1, bit 2 stays 1 after the alarm commit. A later control write with bit 2 = 0 clears it.
- R7: A control write that sets an update bit while that bit reads 1 is ignored, even in the last pending cycle. It causes no extra transfer and does not change the latency.
- R8: A write to the weekday buffer (address 3) is accepted only when exactly one of bits 6..0 is set and bit 7 is clear. Any other value leaves the buffer unchanged.
- R9: On a time load, the hours byte (address 2) is masked with 0x1F when the 24-hour select is 1. It is masked with 0x2F when the select is 0, which keeps the PM flag at bit 5 and the hour in bits 3..0.
- R10: On a time load, seconds and minutes are masked with 0x7F, the date with 0x3F and the month with 0x1F. Weekday and year bytes pass through unchanged.
- R11: The mode register is bit 0 = binary select and bit 1 = 24-hour select. It reads back and drives `mode_binary` and `mode_24h`.
- R12: With TWO_YEAR=1 there are eight time bytes. The second year byte at address 7 takes part in loads and snapshots, and the alarm bank has a matching byte at 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| live_time | input | 8*NREG | Current time bytes from the counter core |
| time_load_valid | output | 1 | One-cycle load pulse to the counter core |
| time_load_data | output | 8*NREG | Masked time bytes to load |
| alarm_regs | output | 8*NREG | Committed alarm bytes |
| mode_binary | output | 1 | Binary (1) or BCD (0) counting |
| mode_24h | output | 1 | 24-hour (1) or 12-hour (0) format |

## Verification
The collision that matters is a control write that sets an update bit in the same cycle as that bit's transfer completes. The bench starts a write-update with the fast latency and times a second request so that it lands on the completion edge. It then counts load pulses and watches the bit for several cycles. Exactly one pulse and a bit that stays clear show that the late request was dropped rather than re-armed. Exhaustive sweeps of all 256 weekday values and all 64 hour values in both hour modes check the filter and the commit masks against arithmetic in the bench.

// File: rtl/rtcsh_pkg.sv
package rtcsh_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] ADR_ALM_BASE = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_CTRL     = 5'h10;
  localparam logic [ADDR_W-1:0] ADR_MODE     = 5'h11;
  localparam int CH_N    = 3;   // update channels: write, read, alarm
  localparam int CH_WR   = 0;
  localparam int CH_RD   = 1;
  localparam int CH_AL   = 2;
  localparam int CB_FAST = 4;   // latency select bit in control register
  localparam int IDX_WDAY = 3;

  // mask applied to time byte idx when it is committed to the core
  function automatic logic [7:0] field_mask(input int idx, input logic h24);
    case (idx)
      0, 1:    return 8'h7F;
      2:       return h24 ? 8'h1F : 8'h2F;
      4:       return 8'h3F;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtcsh_upd_chan.sv
module rtcsh_upd_chan #(
  parameter int LAT_SLOW = 16,
  parameter int LAT_FAST = 4,
  parameter bit STICKY   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clr,
  input  logic fast,
  output logic pending,
  output logic done
);
  localparam int LAT_MAX = (LAT_SLOW > LAT_FAST) ? LAT_SLOW : LAT_FAST;
  localparam int CW = $clog2(LAT_MAX + 1);

  logic [CW-1:0] cnt;
  logic          flag;

  assign done    = (cnt == CW'(1));
  assign pending = (cnt != '0) | flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
      if (done && STICKY) flag <= 1'b1;
    end else if (start && !flag) begin
      cnt <= fast ? CW'(LAT_FAST) : CW'(LAT_SLOW);
    end else if (clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rtcsh_regfile.sv
module rtcsh_regfile
  import rtcsh_pkg::*;
#(
  parameter int NREG = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic [CH_N-1:0]     done,
  input  logic [7:0]          ctrl_rd,
  input  logic [8*NREG-1:0]   live_time,
  output logic [7:0]          rdata,
  output logic                load_valid,
  output logic [8*NREG-1:0]   load_data,
  output logic [8*NREG-1:0]   alarm_live,
  output logic [8*NREG-1:0]   snap_o,
  output logic [7:0]          wday_o,
  output logic                mode_bin,
  output logic                mode_h24
);
  logic [NREG-1:0][7:0] tbuf, snap, abuf, alive, tload;
  logic wday_ok;

  assign wday_ok = $onehot(wdata[6:0]) && !wdata[7];

  for (genvar i = 0; i < NREG; i++) begin : g_byte
    localparam logic [ADDR_W-1:0] A_T = ADDR_W'(i);
    localparam logic [ADDR_W-1:0] A_A = ADR_ALM_BASE + ADDR_W'(i);
    localparam logic [7:0] T_RST = (i == IDX_WDAY) ? 8'h01 : 8'h00;
    logic accept;
    assign accept = (i == IDX_WDAY) ? wday_ok : 1'b1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbuf[i]  <= T_RST;
        snap[i]  <= '0;
        abuf[i]  <= '0;
        alive[i] <= '0;
        tload[i] <= '0;
      end else begin
        if (wr_en && addr == A_T && accept) tbuf[i] <= wdata;
        if (wr_en && addr == A_A)           abuf[i] <= wdata;
        if (done[CH_RD]) snap[i]  <= live_time[8*i +: 8];
        if (done[CH_AL]) alive[i] <= abuf[i];
        if (done[CH_WR]) tload[i] <= tbuf[i] & field_mask(i, mode_h24);
      end
    end
    assign load_data[8*i +: 8]  = tload[i];
    assign alarm_live[8*i +: 8] = alive[i];
    assign snap_o[8*i +: 8]     = snap[i];
  end

  assign wday_o = tbuf[IDX_WDAY];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_bin   <= 1'b0;
      mode_h24   <= 1'b0;
      load_valid <= 1'b0;
    end else begin
      load_valid <= done[CH_WR];
      if (wr_en && addr == ADR_MODE) begin
        mode_bin <= wdata[0];
        mode_h24 <= wdata[1];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == ADDR_W'(i))                 rdata = snap[i];
      if (addr == ADR_ALM_BASE + ADDR_W'(i))  rdata = abuf[i];
    end
    if (addr == ADR_CTRL) rdata = ctrl_rd;
    if (addr == ADR_MODE) rdata = {6'b0, mode_h24, mode_bin};
  end
endmodule

// File: rtl/rtcsh_ctrl.sv
module rtcsh_ctrl
  import rtcsh_pkg::*;
#(
  parameter bit TWO_YEAR     = 1'b0,
  parameter int LAT_SLOW     = 16,
  parameter int LAT_FAST     = 4,
  parameter bit ALARM_STICKY = 1'b0,
  localparam int NREG = TWO_YEAR ? 8 : 7,
  localparam int TW   = 8 * NREG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [4:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [TW-1:0] live_time,
  output logic          time_load_valid,
  output logic [TW-1:0] time_load_data,
  output logic [TW-1:0] alarm_regs,
  output logic          mode_binary,
  output logic          mode_24h
);
  logic            ctrl_wr;
  logic            fast_sel;
  logic [CH_N-1:0] pend, done;
  logic [7:0]      ctrl_rd;
  logic [TW-1:0]   snap;
  logic [7:0]      wday_buf;

  assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n)       fast_sel <= 1'b0;
    else if (ctrl_wr) fast_sel <= bus_wdata[CB_FAST];
  end

  for (genvar k = 0; k < CH_N; k++) begin : g_chan
    localparam bit STK = (k == CH_AL) ? ALARM_STICKY : 1'b0;
    rtcsh_upd_chan #(
      .LAT_SLOW(LAT_SLOW), .LAT_FAST(LAT_FAST), .STICKY(STK)
    ) u_chan (
      .clk(clk), .rst_n(rst_n),
      .start(ctrl_wr && bus_wdata[k]),
      .clr(ctrl_wr && !bus_wdata[k]),
      .fast(bus_wdata[CB_FAST]),
      .pending(pend[k]),
      .done(done[k])
    );
  end

  assign ctrl_rd = {3'b0, fast_sel, 1'b0, pend};

  rtcsh_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .done(done), .ctrl_rd(ctrl_rd), .live_time(live_time),
    .rdata(bus_rdata),
    .load_valid(time_load_valid), .load_data(time_load_data),
    .alarm_live(alarm_regs), .snap_o(snap), .wday_o(wday_buf),
    .mode_bin(mode_binary), .mode_h24(mode_24h)
  );
endmodule

// File: rtl/rtcsh_ctrl_chk.sv
module rtcsh_ctrl_chk #(
  parameter int TW = 56
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    pend,
  input logic [2:0]    done,
  input logic          time_load_valid,
  input logic [TW-1:0] alarm_regs,
  input logic [TW-1:0] snap,
  input logic [7:0]    wday_buf
);
  // R2: the write-update bit falls exactly when the load pulse appears
  p_load_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend[0]) |-> time_load_valid);

  // R2: the write-update bit does not drop before its transfer completes
  p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend[0]) && !$past(done[0])) |-> pend[0]);

  // R7: a re-request can never produce back-to-back loads
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    time_load_valid |=> !time_load_valid);

  // R4: the snapshot only moves on a read-update completion
  p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done[1]) |-> $stable(snap));

  // R5: committed alarm only moves on an alarm-update completion
  p_alarm_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done[2]) |-> $stable(alarm_regs));

  // R8: the weekday buffer always holds a legal one-hot day
  p_wday_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(wday_buf[6:0]) && !wday_buf[7]);
endmodule

bind rtcsh_ctrl rtcsh_ctrl_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .done(done),
  .time_load_valid(time_load_valid), .alarm_regs(alarm_regs),
  .snap(snap), .wday_buf(wday_buf)
);

// File: tb/test_rtcsh_ctrl.sv
module test_rtcsh_ctrl;
  localparam int LS = 12, LF = 3, NR = 8, TW = 8 * NR;
  localparam logic [4:0] A_CTRL = 5'h10, A_MODE = 5'h11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, rdata, rdata2;
  logic [TW-1:0] live_time = '0, ld_data, ld_data2, alm, alm2;
  logic ld_valid, ld_valid2, mbin, mh24, mbin2, mh242;

  int checks = 0, fails = 0, pulses = 0;
  logic [7:0] eb [NR];  // bench model of time buffers
  logic h24 = 1'b0;

  always #4 clk = ~clk;

  rtcsh_ctrl #(.TWO_YEAR(1'b1), .LAT_SLOW(LS), .LAT_FAST(LF), .ALARM_STICKY(1'b0)) i_rtcsh_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .live_time(live_time), .time_load_valid(ld_valid),
    .time_load_data(ld_data), .alarm_regs(alm), .mode_binary(mbin), .mode_24h(mh24));

  rtcsh_ctrl #(.TWO_YEAR(1'b1), .LAT_SLOW(LS), .LAT_FAST(LF), .ALARM_STICKY(1'b1)) i_rtcsh_ctrl_stk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata2), .live_time(live_time), .time_load_valid(ld_valid2),
    .time_load_data(ld_data2), .alarm_regs(alm2), .mode_binary(mbin2), .mode_24h(mh242));

  always @(negedge clk) if (rst_n && ld_valid) pulses++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bmask(input int i, input logic m24);
    if (i == 0 || i == 1) return 8'h7F;
    if (i == 2) return m24 ? 8'h1F : 8'h2F;
    if (i == 4) return 8'h3F;
    if (i == 5) return 8'h1F;
    return 8'hFF;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = A_CTRL;
  endtask

  // start update on channel k and follow the pending bit; leaves bench at completion negedge
  task automatic run_upd(input int k, input bit fast, input string req);
    int lat = fast ? LF : LS;
    wr(A_CTRL, 8'(1 << k) | (fast ? 8'h10 : 8'h00));
    for (int j = 0; j < lat; j++) begin
      chk(rdata[k] == 1'b1, req, rdata[k], 1);
      @(negedge clk);
    end
    chk(rdata[k] == 1'b0, req, rdata[k], 0);
  endtask

  task automatic commit_check(input string req);
    logic [TW-1:0] exp;
    for (int i = 0; i < NR; i++) exp[8*i +: 8] = eb[i] & bmask(i, h24);
    run_upd(0, 1'b1, req);
    chk(ld_valid == 1'b1, req, ld_valid, 1);
    chk(ld_data == exp, req, ld_data, exp);
  endtask

  task automatic set_tbuf(input int i, input logic [7:0] v);
    wr(5'(i), v);
    if (i != 3 || ($onehot(v[6:0]) && !v[7])) eb[i] = v;
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) eb[i] = (i == 3) ? 8'h01 : 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_addr = A_CTRL; #1 chk(rdata == 8'h00, "R1", rdata, 0);
    bus_addr = A_MODE; #1 chk(rdata == 8'h00, "R1", rdata, 0);
    bus_addr = 5'd0;   #1 chk(rdata == 8'h00, "R1", rdata, 0);
    chk(ld_valid == 1'b0, "R1", ld_valid, 0);
    chk(alm == '0, "R1", alm, 0);

    // R11 mode register
    wr(A_MODE, 8'h03); bus_addr = A_MODE; #1
    chk(rdata == 8'h03, "R11", rdata, 3);
    chk(mbin == 1'b1 && mh24 == 1'b1, "R11", {mbin, mh24}, 3);
    wr(A_MODE, 8'h01); bus_addr = A_MODE; #1
    chk(rdata == 8'h01 && mh24 == 1'b0, "R11", rdata, 1);

    // R2/R3/R10/R12: full time commit, slow then fast latency
    for (int i = 0; i < NR; i++) set_tbuf(i, 8'hFF - 8'(i * 17));
    set_tbuf(3, 8'h20);
    h24 = 1'b0;
    run_upd(0, 1'b0, "R3");
    chk(ld_valid == 1'b1, "R2", ld_valid, 1);
    @(negedge clk); chk(ld_valid == 1'b0, "R2", ld_valid, 0);
    bus_addr = A_CTRL; #1 chk(rdata[4] == 1'b0, "R3", rdata, 0);
    for (int i = 0; i < NR; i++) set_tbuf(i, 8'(8'hA5 ^ 8'(i * 29)));
    set_tbuf(3, 8'h40);
    commit_check("R10");
    bus_addr = A_CTRL; #1 chk(rdata[4] == 1'b1, "R3", rdata, 8'h10);
    chk(ld_data[63:56] == eb[7], "R12", ld_data[63:56], eb[7]);

    // R8 exhaustive weekday filter
    for (int v = 0; v < 256; v++) begin
      set_tbuf(3, 8'(v));
      commit_check("R8");
    end

    // R9 hours masks in both modes
    for (int m = 0; m < 2; m++) begin
      wr(A_MODE, 8'(m << 1)); h24 = m[0];
      for (int v = 0; v < 64; v++) begin
        set_tbuf(2, 8'(v) | 8'hC0);
        commit_check("R9");
      end
    end

    // R4 read-update snapshots
    for (int n = 0; n < 12; n++) begin
      logic [TW-1:0] lt;
      for (int i = 0; i < NR; i++) lt[8*i +: 8] = 8'(n * 37 + i * 11 + 5);
      live_time = lt;
      run_upd(1, n[0], "R4");
      live_time = ~lt;
      @(negedge clk);
      for (int i = 0; i < NR; i++) begin
        bus_addr = 5'(i); #1
        chk(rdata == lt[8*i +: 8], "R4", rdata, lt[8*i +: 8]);
      end
    end

    // R5 alarm buffers and commit; R6 sticky variant
    for (int i = 0; i < NR; i++) wr(5'h08 + 5'(i), 8'(8'h80 | 8'(i * 3)));
    for (int i = 0; i < NR; i++) begin
      bus_addr = 5'h08 + 5'(i); #1
      chk(rdata == 8'(8'h80 | 8'(i * 3)), "R5", rdata, 8'h80 | (i * 3));
    end
    chk(alm == '0, "R5", alm, 0);
    run_upd(2, 1'b1, "R5");
    for (int i = 0; i < NR; i++)
      chk(alm[8*i +: 8] == 8'(8'h80 | 8'(i * 3)), "R5", alm[8*i +: 8], 8'h80 | (i * 3));
    chk(rdata2[2] == 1'b1, "R6", rdata2, 4);
    chk(alm2 == alm, "R6", alm2, alm);
    repeat (4) @(negedge clk);
    chk(rdata2[2] == 1'b1, "R6", rdata2, 4);
    wr(A_CTRL, 8'h04);
    chk(rdata2[2] == 1'b1, "R6", rdata2, 4);
    wr(A_CTRL, 8'h00);
    chk(rdata2[2] == 1'b0, "R6", rdata2, 0);

    // R7 re-request while pending: mid-flight and on the completion edge
    pulses = 0;
    wr(A_CTRL, 8'h01);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 8'h11);
    for (int j = 0; j < LS - 5; j++) begin
      chk(rdata[0] == 1'b1, "R7", rdata[0], 1);
      @(negedge clk);
    end
    chk(rdata[0] == 1'b0 && ld_valid == 1'b1, "R7", {rdata[0], ld_valid}, 1);
    wr(A_CTRL, 8'h11);
    repeat (LF - 2) @(negedge clk);
    wr(A_CTRL, 8'h11);
    chk(ld_valid == 1'b1 && rdata[0] == 1'b0, "R7", {ld_valid, rdata[0]}, 2);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk(rdata[0] == 1'b0, "R7", rdata[0], 0);
    end
    chk(pulses == 2, "R7", pulses, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule